// File: doc/BRIEF.md
# Receive-Level Flow Governor

This block runs automatic flow control for one serial channel. It compares the receive FIFO fill level with two programmable marks that form a hysteresis band. When the level reaches the upper (halt) mark, the block tells the far-end sender to stop. It does this by raising `rts_n`, by queuing one Xoff character, or by both. When the level drops to the lower (resume) mark, it releases `rts_n` or queues one Xon character. In the other direction, the block pauses the local transmitter when the far end deasserts CTS or sends an Xoff. It resumes the transmitter on Xon or, if that option is selected, on any received character.

The block sits between the receive shifter and the receive FIFO, and beside the transmit shifter. Received characters pass in as a `rx_valid`/`rx_data` pulse and leave, one cycle later, as a `fifo_valid`/`fifo_data` pulse. When software flow control is on, flow-control characters are removed from this stream. Neither side has back-pressure, because a serial line cannot be stalled.

The flow character to inject is offered as a valid/ready stream. `flow_valid` and `flow_data` stay stable until `flow_ready` is sampled high. A newer request replaces one that has not yet been taken. While a flow character is pending, `tx_en` is held low, so the character goes out ahead of queued data. The transmit shifter samples `tx_en` only when it is about to start a character, so a character already on the line always finishes.

Top module: `rx_flow_governor`

## Requirements
- R1: After reset, `rts_n`=0, `flow_valid`=0, `fifo_valid`=0 and `tx_en`=1. The registers reset to halt=48, resume=16, Xon=0x11, Xoff=0x13 and mode=0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` at `cfg_addr`: 0 halt mark, 1 resume mark, 2 Xon code, 3 Xoff code, 4 mode. A mark written above 64 is stored as 64.
- R3: The hold state is set when the level is at or above the halt mark, and cleared when the level is at or below the resume mark. With mode bit 0 set, `rts_n` shows the hold state one cycle after the level is presented. With bit 0 clear, `rts_n` is 0.
- R4: With mode bit 2 set, entering hold requests the Xoff code and leaving hold requests the Xon code. `flow_valid` rises one cycle after the level is presented.
- R5: `flow_valid` and `flow_data` are held until a cycle in which `flow_ready`=1. A new hold change before that cycle replaces the pending code.
- R6: `tx_en` is 0 whenever `flow_valid` is 1.
- R7: With mode bit 1 set, `cts_n` passes through two synchronizer flops. `tx_en` falls after the second clock edge that sees `cts_n`=1, and rises two edges after `cts_n` returns to 0.
- R8: With mode bit 2 set, a received Xoff code pauses the transmitter (`tx_en`=0 on the next cycle) and a received Xon code ends the pause. Neither code is forwarded to the FIFO. If the two codes are equal, the code acts as Xoff.
- R9: With mode bits 2 and 3 set, any received character other than Xoff ends an Xoff pause. A character that is not a flow code is still forwarded.
- R10: With mode bit 2 clear, every received character is forwarded one cycle later with its data, and the Xon/Xoff codes have no effect on `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_level | input | 7 | Current receive FIFO fill level, 0..64 |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| fifo_valid | output | 1 | Forwarded character strobe to the receive FIFO |
| fifo_data | output | 8 | Forwarded character |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| rts_n | output | 1 | Request-to-send to the far end, active low |
| tx_en | output | 1 | The transmitter may start a new data character |
| flow_valid | output | 1 | A flow character is waiting to be injected |
| flow_ready | input | 1 | The transmit shifter takes the flow character |
| flow_data | output | 8 | Flow character code |

## Verification
The hardest situation to reach is a pending flow character that is replaced before it is taken. To get there, the level must cross the halt mark and then fall through the resume mark while the shifter refuses the Xoff. The bench does this by holding `flow_ready` low across both level changes, then checking that the Xon code is offered and stays offered until it is accepted. The CTS path is checked one edge at a time, so that the two-flop delay shows as exactly one cycle of unchanged `tx_en`.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

  localparam logic [2:0] ADDR_HALT   = 3'd0;
  localparam logic [2:0] ADDR_RESUME = 3'd1;
  localparam logic [2:0] ADDR_XON    = 3'd2;
  localparam logic [2:0] ADDR_XOFF   = 3'd3;
  localparam logic [2:0] ADDR_MODE   = 3'd4;

  // mode register bit layout: [3] any_resume, [2] sw_en, [1] cts_en, [0] rts_en
  typedef struct packed {
    logic any_resume;
    logic sw_en;
    logic cts_en;
    logic rts_en;
  } mode_t;

endpackage

// File: rtl/rfg_cfg_regs.sv
module rfg_cfg_regs
  import rfg_pkg::*;
#(
  parameter int RX_DEPTH    = 64,
  parameter int CHAR_W      = 8,
  parameter int HALT_INIT   = 48,
  parameter int RESUME_INIT = 16,
  parameter int XON_INIT    = 8'h11,
  parameter int XOFF_INIT   = 8'h13,
  localparam int LVL_W      = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CHAR_W-1:0] cfg_wdata,
  output logic [LVL_W-1:0]  halt_lvl,
  output logic [LVL_W-1:0]  resume_lvl,
  output logic [CHAR_W-1:0] xon_code,
  output logic [CHAR_W-1:0] xoff_code,
  output mode_t             mode
);

  function automatic logic [LVL_W-1:0] clamp_lvl(input logic [CHAR_W-1:0] v);
    if (int'(v) > RX_DEPTH) return LVL_W'(RX_DEPTH);
    return LVL_W'(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_lvl   <= LVL_W'(HALT_INIT);
      resume_lvl <= LVL_W'(RESUME_INIT);
      xon_code   <= CHAR_W'(XON_INIT);
      xoff_code  <= CHAR_W'(XOFF_INIT);
      mode       <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_HALT:   halt_lvl   <= clamp_lvl(cfg_wdata);
        ADDR_RESUME: resume_lvl <= clamp_lvl(cfg_wdata);
        ADDR_XON:    xon_code   <= cfg_wdata;
        ADDR_XOFF:   xoff_code  <= cfg_wdata;
        ADDR_MODE:   mode       <= mode_t'(cfg_wdata[3:0]);
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/rfg_level_watch.sv
module rfg_level_watch #(
  parameter int  RX_DEPTH = 64,
  localparam int LVL_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic             sw_en,
  input  logic             flow_ready,
  output logic             hold_q,
  output logic             pend_q,
  output logic             pend_xoff_q
);

  logic hold_d;
  logic rise;
  logic fall;

  // hysteresis: enter at/above halt, leave at/below resume
  always_comb begin
    hold_d = hold_q;
    if (!hold_q && (rx_level >= halt_lvl))
      hold_d = 1'b1;
    else if (hold_q && (rx_level <= resume_lvl))
      hold_d = 1'b0;
  end

  assign rise = hold_d & ~hold_q;
  assign fall = ~hold_d & hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_xoff_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (sw_en && (rise || fall)) begin
        // newest request wins over one not yet taken
        pend_q      <= 1'b1;
        pend_xoff_q <= rise;
      end else if (pend_q && flow_ready) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rfg_cts_sync.sv
module rfg_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  output logic cts_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], cts_n};
  end

  assign cts_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rfg_rx_filter.sv
module rfg_rx_filter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [CHAR_W-1:0] xon_code,
  input  logic [CHAR_W-1:0] xoff_code,
  input  logic              sw_en,
  input  logic              any_resume,
  output logic              fifo_valid,
  output logic [CHAR_W-1:0] fifo_data,
  output logic              xoff_pause
);

  logic is_xoff;
  logic is_xon;
  logic is_ctrl;

  assign is_xoff = (rx_data == xoff_code);
  assign is_xon  = (rx_data == xon_code) && !is_xoff;
  assign is_ctrl = sw_en && (is_xoff || is_xon);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_valid <= 1'b0;
      fifo_data  <= '0;
      xoff_pause <= 1'b0;
    end else begin
      fifo_valid <= rx_valid && !is_ctrl;
      if (rx_valid) fifo_data <= rx_data;
      if (!sw_en)
        xoff_pause <= 1'b0;
      else if (rx_valid) begin
        if (is_xoff)
          xoff_pause <= 1'b1;
        else if (is_xon || any_resume)
          xoff_pause <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_flow_governor.sv
module rx_flow_governor
  import rfg_pkg::*;
#(
  parameter int  RX_DEPTH   = 64,
  parameter int  CHAR_W     = 8,
  parameter int  CTS_STAGES = 2,
  localparam int LVL_W      = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              fifo_valid,
  output logic [CHAR_W-1:0] fifo_data,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              tx_en,
  output logic              flow_valid,
  input  logic              flow_ready,
  output logic [CHAR_W-1:0] flow_data
);

  logic [LVL_W-1:0]  halt_lvl;
  logic [LVL_W-1:0]  resume_lvl;
  logic [CHAR_W-1:0] xon_code;
  logic [CHAR_W-1:0] xoff_code;
  mode_t             mode;
  logic              hold_q;
  logic              pend_q;
  logic              pend_xoff_q;
  logic              cts_n_sync;
  logic              xoff_pause;

  rfg_cfg_regs #(.RX_DEPTH(RX_DEPTH), .CHAR_W(CHAR_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .halt_lvl, .resume_lvl, .xon_code, .xoff_code, .mode
  );

  rfg_level_watch #(.RX_DEPTH(RX_DEPTH)) u_watch (
    .clk, .rst_n, .rx_level, .halt_lvl, .resume_lvl,
    .sw_en(mode.sw_en), .flow_ready, .hold_q, .pend_q, .pend_xoff_q
  );

  rfg_cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk, .rst_n, .cts_n, .cts_n_sync
  );

  rfg_rx_filter #(.CHAR_W(CHAR_W)) u_filter (
    .clk, .rst_n, .rx_valid, .rx_data, .xon_code, .xoff_code,
    .sw_en(mode.sw_en), .any_resume(mode.any_resume),
    .fifo_valid, .fifo_data, .xoff_pause
  );

  assign rts_n      = mode.rts_en & hold_q;
  assign flow_valid = pend_q;
  assign flow_data  = pend_xoff_q ? xoff_code : xon_code;
  assign tx_en      = !(mode.cts_en & cts_n_sync) && !xoff_pause && !pend_q;

endmodule

// File: rtl/rx_flow_governor_chk.sv
module rx_flow_governor_chk #(
  parameter int LVL_W  = 7,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  rx_level,
  input logic [LVL_W-1:0]  halt_lvl,
  input logic [LVL_W-1:0]  resume_lvl,
  input logic              rts_en,
  input logic              cts_en,
  input logic              sw_en,
  input logic              rts_n,
  input logic              tx_en,
  input logic              cts_n,
  input logic              flow_valid,
  input logic              flow_ready,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic [CHAR_W-1:0] xon_code,
  input logic [CHAR_W-1:0] xoff_code,
  input logic              fifo_valid
);

  p_rts_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_level >= halt_lvl) |=> (rts_n || !rts_en));

  p_rts_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= resume_lvl && rx_level < halt_lvl) |=> !rts_n);

  p_flow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_valid && !flow_ready) |=> flow_valid);

  p_flow_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flow_valid |-> !tx_en);

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && $past(cts_n, 2)) |-> !tx_en);

  p_ctrl_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && rx_valid && (rx_data == xon_code || rx_data == xoff_code)) |=> !fifo_valid);

  p_xoff_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && rx_valid && rx_data == xoff_code) |=> (!tx_en || !sw_en));

endmodule

bind rx_flow_governor rx_flow_governor_chk #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .halt_lvl(halt_lvl),
  .resume_lvl(resume_lvl), .rts_en(mode.rts_en), .cts_en(mode.cts_en),
  .sw_en(mode.sw_en), .rts_n(rts_n), .tx_en(tx_en), .cts_n(cts_n),
  .flow_valid(flow_valid), .flow_ready(flow_ready), .rx_valid(rx_valid),
  .rx_data(rx_data), .xon_code(xon_code), .xoff_code(xoff_code),
  .fifo_valid(fifo_valid)
);

// File: tb/rx_flow_governor_bench.sv
`timescale 1ns/1ps
module rx_flow_governor_bench;

  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [6:0] rx_level = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       fifo_valid;
  logic [7:0] fifo_data;
  logic       cts_n = 1'b0;
  logic       rts_n;
  logic       tx_en;
  logic       flow_valid;
  logic       flow_ready = 1'b0;
  logic [7:0] flow_data;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  rx_flow_governor u_rx_flow_governor (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .rx_level, .rx_valid,
    .rx_data, .fifo_valid, .fifo_data, .cts_n, .rts_n, .tx_en,
    .flow_valid, .flow_ready, .flow_data
  );

  // entry: {level[16:10], rts_n[9], flow_valid[8], flow_data[7:0]}
  localparam int N_VEC = 10;
  localparam logic [16:0] VEC [N_VEC] = '{
    {7'd0,  1'b0, 1'b0, 8'h00},
    {7'd30, 1'b0, 1'b0, 8'h00},
    {7'd48, 1'b1, 1'b1, XOFF},
    {7'd60, 1'b1, 1'b0, 8'h00},
    {7'd30, 1'b1, 1'b0, 8'h00},
    {7'd16, 1'b0, 1'b1, XON},
    {7'd10, 1'b0, 1'b0, 8'h00},
    {7'd47, 1'b0, 1'b0, 8'h00},
    {7'd64, 1'b1, 1'b1, XOFF},
    {7'd0,  1'b0, 1'b1, XON}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rx_char(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    step();
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rts_n", rts_n, 0);
    chk("R1 flow_valid", flow_valid, 0);
    chk("R1 fifo_valid", fifo_valid, 0);
    chk("R1 tx_en", tx_en, 1);

    // R3 with mode bit0 clear: reaching the default halt mark leaves rts_n low
    rx_level = 7'd50; step();
    chk("R3 rts_n disabled", rts_n, 0);
    rx_level = 7'd0; step();

    // table walk: auto-RTS + software flow (mode 0x5), default marks 48/16
    wr(3'd4, 8'h05);
    for (int i = 0; i < N_VEC; i++) begin
      rx_level = VEC[i][16:10];
      step();
      chk("R3 rts_n", rts_n, int'(VEC[i][9]));
      chk("R4 flow_valid", flow_valid, int'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk("R4 flow_data", flow_data, int'(VEC[i][7:0]));
        chk("R6 tx_en during flow", tx_en, 0);
        flow_ready = 1'b1; step(); flow_ready = 1'b0;
        chk("R5 taken", flow_valid, 0);
      end
    end

    // R5 replacement: Xoff not taken, then level drops through resume
    rx_level = 7'd64; step();
    chk("R5 xoff pending", flow_data, int'(XOFF));
    rx_level = 7'd0; step();
    chk("R5 replaced by xon", flow_data, int'(XON));
    repeat (3) step();
    chk("R5 held valid", flow_valid, 1);
    chk("R6 tx_en held", tx_en, 0);
    flow_ready = 1'b1; step(); flow_ready = 1'b0;
    chk("R5 released", flow_valid, 0);
    chk("R6 tx_en back", tx_en, 1);

    // R2 clamp: halt written as 100 stores 64
    wr(3'd0, 8'd100);
    wr(3'd4, 8'h01);
    rx_level = 7'd63; step();
    chk("R2 below clamped halt", rts_n, 0);
    rx_level = 7'd64; step();
    chk("R2 at clamped halt", rts_n, 1);
    rx_level = 7'd0; step();
    chk("R2 resume", rts_n, 0);
    wr(3'd0, 8'd48);

    // R7 CTS path
    wr(3'd4, 8'h02);
    cts_n = 1'b1; step();
    chk("R7 one edge", tx_en, 1);
    step();
    chk("R7 two edges", tx_en, 0);
    cts_n = 1'b0; step();
    chk("R7 release one edge", tx_en, 0);
    step();
    chk("R7 release two edges", tx_en, 1);

    // R8 software receive codes, new codes via R2 writes
    wr(3'd2, 8'h21);
    wr(3'd3, 8'h23);
    wr(3'd4, 8'h04);
    rx_char(8'h23);
    chk("R8 xoff pauses", tx_en, 0);
    chk("R8 xoff dropped", fifo_valid, 0);
    rx_char(8'h41);
    chk("R8 plain forwarded", fifo_valid, 1);
    chk("R8 plain data", fifo_data, 8'h41);
    chk("R8 plain no resume", tx_en, 0);
    rx_char(8'h21);
    chk("R8 xon resumes", tx_en, 1);
    chk("R8 xon dropped", fifo_valid, 0);

    // R9 any-character resume
    wr(3'd4, 8'h0C);
    rx_char(8'h23);
    chk("R9 paused", tx_en, 0);
    rx_char(8'h42);
    chk("R9 any resumes", tx_en, 1);
    chk("R9 forwarded", fifo_valid, 1);
    chk("R9 data", fifo_data, 8'h42);

    // R10 software flow off: codes are plain data
    wr(3'd4, 8'h00);
    rx_char(8'h23);
    chk("R10 xoff forwarded", fifo_valid, 1);
    chk("R10 xoff data", fifo_data, 8'h23);
    chk("R10 tx_en unaffected", tx_en, 1);
    step();
    chk("R10 single pulse", fifo_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule